// File: doc/BRIEF.md
# Operand Effective Address Unit

This block resolves operand addresses for a 16-bit processor that keeps compatibility with an older 8-bit core. The sequencer in the core hands it a mode code, an access type, the operand bytes already taken from the instruction stream, and a snapshot of the direct-page, stack, index and bank registers together with the emulation and index-width flags. The block returns a 24-bit effective address and the number of extra internal cycles the mode costs. It also keeps the byte last seen on the data bus (the open-bus value).

Modes that dereference a pointer read it one byte per cycle through a simple valid/ready read port. Each pointer byte address follows one of two wrap rules. With the page rule the low 8 address bits wrap and bits 23:8 stay fixed. With the bank rule the low 16 bits wrap and bits 23:16 stay fixed. The unit accepts `start` only when it is idle. It raises `done` for a single cycle, and during that cycle `ea` and `xcyc` are valid.

Top module: `ea_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `obus` to 0x00 and returns the unit to idle (`busy`, `done` and `mem_req` all low). Mode codes are: 0 d, 1 d,X, 2 d,Y, 3 (d), 4 (d,X), 5 (d),Y, 6 [d], 7 [d],Y, 8 a, 9 a,X, 10 a,Y, 11 long, 12 long,X, 13 (a), 14 (a,X), 15 [a], 16 stack-relative, 17 (s,S),Y, 18 short branch, 19 long branch. Access codes are: 0 none, 1 read, 2 write, 3 modify, 5 jump, 8 call. Bit 0 marks a read and bit 1 marks a write.
- R2: Mode d returns {0x00, (D + operand byte) mod 2^16}. It costs 1 extra cycle when D[7:0] is nonzero and 0 otherwise.
- R3: Modes d,X and d,Y cost one cycle more than mode d. When emulation is on and D[7:0] is zero, only the index low byte is added, and only to address bits 7:0, so the address stays in its page. In every other case the full 16-bit index is added modulo 2^16.
- R4: Modes (d) and (d,X) read a 2-byte pointer, low byte first, starting at the mode-d (or d,X) address in bank 0. The second byte uses the page rule when emulation is on and D[7:0] is zero, and the bank rule otherwise. The result is {data bank, pointer}. (d,X) costs one cycle more than (d).
- R5: Modes a,X and a,Y return {data bank, operand16} plus the index, modulo 2^24. Mode (d),Y adds Y to the (d) result in the same way. These three modes charge one extra index cycle when any of the following holds: the access has the write bit, the index width flag is 0 (16-bit indexes), or the base low byte plus the index low byte reaches 0x100.
- R6: Mode (a,X) reads a 2-byte pointer at {program bank, operand16 + X} under the bank rule, costs 1 extra cycle and returns {program bank, pointer}. Mode (a) reads at {0x00, operand16} and returns {program bank, pointer} with no extra cycle.
- R7: Modes [d] and [a] read a 3-byte pointer under the bank rule, and the third byte becomes address bits 23:16. Mode [d],Y adds Y to that result, and long,X adds X to operand24, both modulo 2^24. Mode long returns operand24. None of these charges index cycles.
- R8: Stack-relative mode returns {0x00, S + operand byte} and costs 1 cycle. Mode (s,S),Y reads a 2-byte pointer there under the bank rule, returns ({data bank, pointer} + Y) mod 2^24, and costs 2 cycles.
- R9: The short branch returns {program bank, PC + sign-extended operand byte}. The long branch adds operand16 instead. Both wrap to 16 bits and cost 0 cycles.
- R10: When a request is accepted, `obus` takes one of these values. For a long or long,X call it takes the program bank. For an (a,X) call it takes PC[7:0]. If the access has the read bit, or the mode reads a pointer, it takes the last operand byte. Otherwise it is unchanged. Every pointer byte read then overwrites it.
- R11: A non-pointer mode raises `done` in the cycle after the request is accepted. A pointer mode issues one read per cycle in which `mem_ready` is high and holds `mem_addr` while `mem_ready` is low. `done` lasts one cycle, and `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; accepted when not busy |
| mode | input | 5 | Addressing mode code |
| acc | input | 4 | Access type code |
| opnd | input | 24 | Operand bytes, first byte in bits 7:0 |
| pc | input | 16 | Program counter after the operand |
| pbank | input | 8 | Program bank |
| dbank | input | 8 | Data bank |
| dpage | input | 16 | Direct-page register D |
| sptr | input | 16 | Stack pointer S |
| xreg | input | 16 | Index X |
| yreg | input | 16 | Index Y |
| emu | input | 1 | Emulation mode flag |
| idx8 | input | 1 | Index registers are 8-bit |
| mem_req | output | 1 | Pointer byte read valid |
| mem_addr | output | 24 | Pointer byte address |
| mem_ready | input | 1 | Read accepted, data present |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 24 | Effective address, valid with done |
| xcyc | output | 2 | Extra internal cycles, valid with done |
| obus | output | 8 | Open-bus byte |

## Verification
The request is accepted on the first rising edge with `start` high, and the cycles are counted from there. With `mem_ready` held high, `done` is due after as many cycles as the mode has pointer bytes: 0, 2 or 3. Every directed case samples on the falling edge and compares that latency exactly. The bench also reads `ea`, `xcyc` and `obus` on that same falling edge. `obus` changes on the request edge for non-pointer modes and on each accepted read otherwise. The transient program-counter byte of an (a,X) call is therefore sampled on the first falling edge after acceptance, before any read is taken. When `mem_ready` is stalled, only a lower bound on latency is checked, together with the single `done` pulse.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 24;
  localparam int XC_W    = 2;
  localparam int MODE_W  = 5;
  localparam int ACC_W   = 4;
  localparam int PTR_MAX = 3;
  localparam int CNT_W   = $clog2(PTR_MAX + 1);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [MODE_W-1:0] {
    M_DIR    = 5'd0,
    M_DIRX   = 5'd1,
    M_DIRY   = 5'd2,
    M_DIND   = 5'd3,
    M_DXIND  = 5'd4,
    M_DINDY  = 5'd5,
    M_DINDL  = 5'd6,
    M_DINDLY = 5'd7,
    M_ABS    = 5'd8,
    M_ABSX   = 5'd9,
    M_ABSY   = 5'd10,
    M_ABSL   = 5'd11,
    M_ABSLX  = 5'd12,
    M_AIND   = 5'd13,
    M_AXIND  = 5'd14,
    M_AINDL  = 5'd15,
    M_SREL   = 5'd16,
    M_SRINDY = 5'd17,
    M_REL    = 5'd18,
    M_RELL   = 5'd19
  } ea_mode_e;

  localparam logic [ACC_W-1:0] ACC_NONE = 4'd0;
  localparam logic [ACC_W-1:0] ACC_RD   = 4'd1;
  localparam logic [ACC_W-1:0] ACC_WR   = 4'd2;
  localparam logic [ACC_W-1:0] ACC_RMW  = 4'd3;
  localparam logic [ACC_W-1:0] ACC_JMP  = 4'd5;
  localparam logic [ACC_W-1:0] ACC_CALL = 4'd8;

  typedef enum logic {WR_BANK = 1'b0, WR_PAGE = 1'b1} wrap_e;

  typedef struct packed {
    ea_mode_e          mode;
    logic [ACC_W-1:0]  acc;
    addr_t             opnd;
    word_t             pc;
    byte_t             pb;
    byte_t             db;
    word_t             dp;
    word_t             sp;
    word_t             x;
    word_t             y;
    logic              emu;
    logic              idx8;
  } ea_ctx_t;

  typedef struct packed {
    logic [CNT_W-1:0] nbytes;
    addr_t            base;
    wrap_e            wrap;
  } fetch_plan_t;

  function automatic logic dl_nz(word_t dp);
    return dp[7:0] != 8'h00;
  endfunction

  function automatic logic page_rule(logic emu, word_t dp);
    return emu && !dl_nz(dp);
  endfunction

  function automatic word_t direct_sum(word_t dp, byte_t off);
    return dp + {8'h00, off};
  endfunction

  function automatic word_t direct_index(word_t base, word_t idx, logic pagem);
    byte_t lo;
    lo = base[7:0] + idx[7:0];
    if (pagem) return {base[15:8], lo};
    return base + idx;
  endfunction

  function automatic logic cross_pen(byte_t lo, byte_t ilo, logic wr, logic idx8);
    logic [BYTE_W:0] s;
    s = {1'b0, lo} + {1'b0, ilo};
    return wr || !idx8 || s[BYTE_W];
  endfunction

  function automatic addr_t ptr_byte_addr(addr_t base, logic [CNT_W-1:0] k, wrap_e w);
    byte_t lo;
    word_t lw;
    lo = base[7:0] + BYTE_W'(k);
    lw = base[15:0] + WORD_W'(k);
    if (w == WR_PAGE) return {base[23:8], lo};
    return {base[23:16], lw};
  endfunction

  function automatic word_t rel_target(word_t pc, word_t off, logic lng);
    word_t soff;
    soff = lng ? off : {{8{off[7]}}, off[7:0]};
    return pc + soff;
  endfunction

  function automatic logic [1:0] operand_len(ea_mode_e m);
    case (m)
      M_ABS, M_ABSX, M_ABSY, M_AIND, M_AXIND, M_RELL: return 2'd2;
      M_ABSL, M_ABSLX, M_AINDL:                       return 2'd3;
      default:                                        return 2'd1;
    endcase
  endfunction

  function automatic fetch_plan_t plan_fetch(ea_ctx_t c);
    fetch_plan_t p;
    word_t d16;
    logic  pm;
    d16 = direct_sum(c.dp, c.opnd[7:0]);
    pm  = page_rule(c.emu, c.dp);
    p.nbytes = '0;
    p.base   = '0;
    p.wrap   = WR_BANK;
    case (c.mode)
      M_DIND, M_DINDY: begin
        p.nbytes = CNT_W'(2);
        p.base   = {8'h00, d16};
        p.wrap   = pm ? WR_PAGE : WR_BANK;
      end
      M_DXIND: begin
        p.nbytes = CNT_W'(2);
        p.base   = {8'h00, direct_index(d16, c.x, pm)};
        p.wrap   = pm ? WR_PAGE : WR_BANK;
      end
      M_DINDL, M_DINDLY: begin
        p.nbytes = CNT_W'(3);
        p.base   = {8'h00, d16};
      end
      M_AIND: begin
        p.nbytes = CNT_W'(2);
        p.base   = {8'h00, c.opnd[15:0]};
      end
      M_AINDL: begin
        p.nbytes = CNT_W'(3);
        p.base   = {8'h00, c.opnd[15:0]};
      end
      M_AXIND: begin
        p.nbytes = CNT_W'(2);
        p.base   = {c.pb, c.opnd[15:0] + c.x};
      end
      M_SRINDY: begin
        p.nbytes = CNT_W'(2);
        p.base   = {8'h00, c.sp + {8'h00, c.opnd[7:0]}};
      end
      default: ;
    endcase
    return p;
  endfunction

  function automatic byte_t obus_at_launch(ea_ctx_t c, byte_t cur, logic has_ptr);
    logic [1:0] n;
    n = operand_len(c.mode);
    if ((c.mode == M_ABSL || c.mode == M_ABSLX) && c.acc == ACC_CALL) return c.pb;
    if (c.mode == M_AXIND && c.acc == ACC_CALL) return c.pc[7:0];
    if (c.acc[0] || has_ptr) begin
      case (n)
        2'd3:    return c.opnd[23:16];
        2'd2:    return c.opnd[15:8];
        default: return c.opnd[7:0];
      endcase
    end
    return cur;
  endfunction

endpackage

// File: rtl/ea_fetch_seq.sv
module ea_fetch_seq
  import ea_pkg::*;
#(
  parameter int MAX_BYTES = PTR_MAX
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      launch,
  input  fetch_plan_t               plan,
  input  logic                      mem_ready,
  input  byte_t                     mem_rdata,
  output logic                      mem_req,
  output addr_t                     mem_addr,
  output logic [MAX_BYTES*BYTE_W-1:0] ptr,
  output logic                      busy,
  output logic                      fin,
  output logic                      byte_vld,
  output byte_t                     byte_val
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_FIN} seq_state_e;

  seq_state_e        state;
  fetch_plan_t       plan_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  byte_t             ptr_b [MAX_BYTES];

  assign last_idx = plan_q.nbytes - CNT_W'(1);
  assign mem_req  = (state == S_FETCH);
  assign mem_addr = ptr_byte_addr(plan_q.base, cnt, plan_q.wrap);
  assign busy     = (state != S_IDLE);
  assign fin      = (state == S_FIN);
  assign byte_vld = mem_req && mem_ready;
  assign byte_val = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      plan_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          plan_q <= plan;
          cnt    <= '0;
          state  <= (plan.nbytes == '0) ? S_FIN : S_FETCH;
        end
        S_FETCH: if (mem_ready) begin
          if (cnt == last_idx) state <= S_FIN;
          else                 cnt   <= cnt + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || launch) ptr_b[g] <= '0;
      else if (byte_vld && cnt == CNT_W'(g)) ptr_b[g] <= mem_rdata;
    end
    assign ptr[g*BYTE_W +: BYTE_W] = ptr_b[g];
  end

endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
(
  input  ea_ctx_t          ctx,
  input  addr_t            ptr,
  output addr_t            ea,
  output logic [XC_W-1:0]  xcyc
);

  word_t            d16;
  logic             dln;
  logic             pm;
  logic             wr;
  word_t            p16;
  logic [XC_W-1:0]  xc_dl;
  addr_t            db_ptr;
  addr_t            db_abs;

  assign d16    = direct_sum(ctx.dp, ctx.opnd[7:0]);
  assign dln    = dl_nz(ctx.dp);
  assign pm     = page_rule(ctx.emu, ctx.dp);
  assign wr     = ctx.acc[1];
  assign p16    = ptr[15:0];
  assign xc_dl  = XC_W'(dln);
  assign db_ptr = {ctx.db, p16};
  assign db_abs = {ctx.db, ctx.opnd[15:0]};

  always_comb begin
    ea   = '0;
    xcyc = '0;
    case (ctx.mode)
      M_DIR: begin
        ea = {8'h00, d16};  xcyc = xc_dl;
      end
      M_DIRX: begin
        ea = {8'h00, direct_index(d16, ctx.x, pm)};  xcyc = xc_dl + XC_W'(1);
      end
      M_DIRY: begin
        ea = {8'h00, direct_index(d16, ctx.y, pm)};  xcyc = xc_dl + XC_W'(1);
      end
      M_DIND: begin
        ea = db_ptr;  xcyc = xc_dl;
      end
      M_DXIND: begin
        ea = db_ptr;  xcyc = xc_dl + XC_W'(1);
      end
      M_DINDY: begin
        ea   = db_ptr + {8'h00, ctx.y};
        xcyc = xc_dl + XC_W'(cross_pen(p16[7:0], ctx.y[7:0], wr, ctx.idx8));
      end
      M_DINDL: begin
        ea = ptr;  xcyc = xc_dl;
      end
      M_DINDLY: begin
        ea = ptr + {8'h00, ctx.y};  xcyc = xc_dl;
      end
      M_ABS: ea = db_abs;
      M_ABSX: begin
        ea   = db_abs + {8'h00, ctx.x};
        xcyc = XC_W'(cross_pen(ctx.opnd[7:0], ctx.x[7:0], wr, ctx.idx8));
      end
      M_ABSY: begin
        ea   = db_abs + {8'h00, ctx.y};
        xcyc = XC_W'(cross_pen(ctx.opnd[7:0], ctx.y[7:0], wr, ctx.idx8));
      end
      M_ABSL:  ea = ctx.opnd;
      M_ABSLX: ea = ctx.opnd + {8'h00, ctx.x};
      M_AIND:  ea = {ctx.pb, p16};
      M_AXIND: begin
        ea = {ctx.pb, p16};  xcyc = XC_W'(1);
      end
      M_AINDL: ea = ptr;
      M_SREL: begin
        ea = {8'h00, ctx.sp + {8'h00, ctx.opnd[7:0]}};  xcyc = XC_W'(1);
      end
      M_SRINDY: begin
        ea = db_ptr + {8'h00, ctx.y};  xcyc = XC_W'(2);
      end
      M_REL:  ea = {ctx.pb, rel_target(ctx.pc, ctx.opnd[15:0], 1'b0)};
      M_RELL: ea = {ctx.pb, rel_target(ctx.pc, ctx.opnd[15:0], 1'b1)};
      default: ;
    endcase
  end

endmodule

// File: rtl/ea_obus.sv
module ea_obus
  import ea_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    launch,
  input  ea_ctx_t ctx_in,
  input  logic    has_ptr,
  input  logic    byte_vld,
  input  byte_t   byte_val,
  output byte_t   obus
);

  always_ff @(posedge clk) begin
    if (rst)           obus <= 8'h00;
    else if (byte_vld) obus <= byte_val;
    else if (launch)   obus <= obus_at_launch(ctx_in, obus, has_ptr);
  end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [MODE_W-1:0]   mode,
  input  logic [ACC_W-1:0]    acc,
  input  logic [ADDR_W-1:0]   opnd,
  input  logic [WORD_W-1:0]   pc,
  input  logic [BYTE_W-1:0]   pbank,
  input  logic [BYTE_W-1:0]   dbank,
  input  logic [WORD_W-1:0]   dpage,
  input  logic [WORD_W-1:0]   sptr,
  input  logic [WORD_W-1:0]   xreg,
  input  logic [WORD_W-1:0]   yreg,
  input  logic                emu,
  input  logic                idx8,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ready,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [ADDR_W-1:0]   ea,
  output logic [XC_W-1:0]     xcyc,
  output logic [BYTE_W-1:0]   obus
);

  ea_ctx_t      ctx_in;
  ea_ctx_t      ctx_q;
  fetch_plan_t  plan;
  logic         launch;
  logic         has_ptr;
  addr_t        ptr;
  logic         byte_vld;
  byte_t        byte_val;
  logic         fin;

  // named internal events for the checker
  ea_mode_e     run_mode;
  byte_t        run_pb;

  assign ctx_in = '{mode: ea_mode_e'(mode), acc: acc, opnd: opnd, pc: pc,
                    pb: pbank, db: dbank, dp: dpage, sp: sptr, x: xreg,
                    y: yreg, emu: emu, idx8: idx8};
  assign launch  = start && !busy;
  assign plan    = plan_fetch(ctx_in);
  assign has_ptr = (plan.nbytes != '0);
  assign run_mode = ctx_q.mode;
  assign run_pb   = ctx_q.pb;
  assign done     = fin;

  always_ff @(posedge clk) begin
    if (rst)         ctx_q <= '0;
    else if (launch) ctx_q <= ctx_in;
  end

  ea_fetch_seq #(.MAX_BYTES(PTR_MAX)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .plan      (plan),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .ptr       (ptr),
    .busy      (busy),
    .fin       (fin),
    .byte_vld  (byte_vld),
    .byte_val  (byte_val)
  );

  ea_calc u_calc (
    .ctx  (ctx_q),
    .ptr  (ptr),
    .ea   (ea),
    .xcyc (xcyc)
  );

  ea_obus u_obus (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .ctx_in   (ctx_in),
    .has_ptr  (has_ptr),
    .byte_vld (byte_vld),
    .byte_val (byte_val),
    .obus     (obus)
  );

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [MODE_W-1:0]  mode,
  input logic               busy,
  input logic               done,
  input logic               mem_req,
  input logic               mem_ready,
  input addr_t              mem_addr,
  input logic [XC_W-1:0]    xcyc,
  input byte_t              obus,
  input ea_mode_e           run_mode,
  input byte_t              run_pb
);

  // R1
  reset_obus_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (obus == 8'h00 && !busy && !done));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R11
  req_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && done));

  // R11
  direct_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mode == M_DIR || mode == M_ABS || mode == M_REL)) |=> done);

  // R6
  prog_bank_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && run_mode == M_AXIND) |-> (mem_addr[23:16] == run_pb));

  // R8
  stack_cost_chk: assert property (@(posedge clk) disable iff (rst)
    (done && run_mode == M_SREL) |-> (xcyc == 2'd1));

endmodule

bind ea_unit ea_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mode      (mode),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .xcyc      (xcyc),
  .obus      (obus),
  .run_mode  (run_mode),
  .run_pb    (run_pb)
);

// File: tb/ea_unit_bench.sv
`timescale 1ns/100ps
module ea_unit_bench;
  import ea_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [4:0]  mode;
  logic [3:0]  acc;
  logic [23:0] opnd;
  logic [15:0] pc;
  logic [7:0]  pbank, dbank;
  logic [15:0] dpage, sptr, xreg, yreg;
  logic        emu, idx8;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_ready;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [23:0] ea;
  logic [1:0]  xcyc;
  logic [7:0]  obus;

  logic        stall = 1'b0;
  logic        tick = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [23:0] c_ea;
  logic [1:0]  c_xc;
  logic [7:0]  c_ob;

  always #2.5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  function automatic logic [7:0] mb(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ (a[23:16] + 8'h3C);
  endfunction

  assign mem_rdata = mb(mem_addr);
  assign mem_ready = stall ? tick : 1'b1;

  ea_unit u_ea_unit (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .acc(acc), .opnd(opnd),
    .pc(pc), .pbank(pbank), .dbank(dbank), .dpage(dpage), .sptr(sptr),
    .xreg(xreg), .yreg(yreg), .emu(emu), .idx8(idx8), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea(ea), .xcyc(xcyc), .obus(obus)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    mode = M_DIR; acc = ACC_RD; opnd = '0; pc = '0; pbank = 8'h7E; dbank = 8'h12;
    dpage = '0; sptr = 16'h01FF; xreg = '0; yreg = '0; emu = 1'b0; idx8 = 1'b1;
  endtask

  task automatic go(output int lat);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    c_ea = ea; c_xc = xcyc; c_ob = obus;
  endtask

  task automatic run(input string tag, input logic [23:0] exp_ea,
                     input logic [1:0] exp_xc, input int exp_lat);
    int lat;
    go(lat);
    chk({tag, " ea"}, c_ea, exp_ea);
    chk({tag, " xcyc"}, {22'd0, c_xc}, {22'd0, exp_xc});
    chk({tag, " latency"}, 24'(lat), 24'(exp_lat));
  endtask

  task automatic t_reset();
    chk("R1 obus after reset", {16'd0, obus}, 24'h0);
    chk("R1 busy/done/req after reset", {21'd0, busy, done, mem_req}, 24'h0);
  endtask

  task automatic t_direct();
    defaults(); mode = M_DIR; dpage = 16'h1200; opnd = 24'h34;
    run("R2 d, DL zero", 24'h001234, 2'd0, 0);
    dpage = 16'h12F0; opnd = 24'h20;
    run("R2 d, DL nonzero", 24'h001310, 2'd1, 0);
    dpage = 16'hFFF0;
    run("R2 d, 16-bit wrap", 24'h000010, 2'd1, 0);
  endtask

  task automatic t_dindex();
    defaults(); mode = M_DIRX; emu = 1'b1; dpage = 16'h0100; xreg = 16'h00F5; opnd = 24'h20;
    run("R3 d,X emu page wrap", 24'h000115, 2'd1, 0);
    emu = 1'b0;
    run("R3 d,X native", 24'h000215, 2'd1, 0);
    emu = 1'b1; dpage = 16'h0101;
    run("R3 d,X emu DL nonzero", 24'h000216, 2'd2, 0);
    mode = M_DIRY; dpage = 16'h0300; yreg = 16'h00E0; opnd = 24'h30;
    run("R3 d,Y emu page wrap", 24'h000310, 2'd1, 0);
  endtask

  task automatic t_dind_wrap();
    defaults(); mode = M_DIND; emu = 1'b1; dpage = 16'h0200; opnd = 24'hFF;
    run("R4 (d) page wrap", {8'h12, mb(24'h000200), mb(24'h0002FF)}, 2'd0, 2);
    emu = 1'b0;
    run("R4 (d) bank wrap", {8'h12, mb(24'h000300), mb(24'h0002FF)}, 2'd0, 2);
    dpage = 16'hFF00;
    run("R4 (d) bank 0 wrap", {8'h12, mb(24'h000000), mb(24'h00FFFF)}, 2'd0, 2);
    mode = M_DXIND; emu = 1'b1; dpage = 16'h0200; xreg = 16'h0001; opnd = 24'hFE;
    run("R4 (d,X) page wrap", {8'h12, mb(24'h000200), mb(24'h0002FF)}, 2'd1, 2);
  endtask

  task automatic t_penalty();
    logic [15:0] p;
    defaults(); mode = M_ABSX; opnd = 24'h12F0; xreg = 16'h0010;
    run("R5 a,X page cross", 24'h121300, 2'd1, 0);
    xreg = 16'h0005;
    run("R5 a,X no cross", 24'h1212F5, 2'd0, 0);
    acc = ACC_WR;
    run("R5 a,X write", 24'h1212F5, 2'd1, 0);
    acc = ACC_RD; idx8 = 1'b0; xreg = 16'h0105;
    run("R5 a,X 16-bit index", 24'h1213F5, 2'd1, 0);
    mode = M_ABSY; opnd = 24'hFFF0; yreg = 16'h0020;
    run("R5 a,Y bank carry", 24'h130010, 2'd1, 0);
    mode = M_DINDY; idx8 = 1'b1; dpage = 16'h0000; opnd = 24'h40; yreg = 16'h0003;
    p = {mb(24'h000041), mb(24'h000040)};
    run("R5 (d),Y small index", {8'h12, p} + 24'h3,
        2'(({1'b0, p[7:0]} + 9'd3) >= 9'h100), 2);
    yreg = 16'h00F0;
    run("R5 (d),Y large index", {8'h12, p} + 24'hF0,
        2'(({1'b0, p[7:0]} + 9'hF0) >= 9'h100), 2);
  endtask

  task automatic t_absxind();
    defaults(); mode = M_AXIND; opnd = 24'hFFFE; xreg = 16'h0001;
    run("R6 (a,X) bank wrap", {8'h7E, mb(24'h7E0000), mb(24'h7EFFFF)}, 2'd1, 2);
    mode = M_AIND; opnd = 24'h1234;
    run("R6 (a)", {8'h7E, mb(24'h001235), mb(24'h001234)}, 2'd0, 2);
  endtask

  task automatic t_long();
    logic [23:0] p;
    defaults(); mode = M_DINDL; opnd = 24'h40;
    p = {mb(24'h000042), mb(24'h000041), mb(24'h000040)};
    run("R7 [d]", p, 2'd0, 3);
    mode = M_DINDLY; yreg = 16'h1234;
    run("R7 [d],Y", p + 24'h1234, 2'd0, 3);
    mode = M_ABSLX; opnd = 24'h12FFF0; xreg = 16'h0020;
    run("R7 long,X", 24'h130010, 2'd0, 0);
    mode = M_ABSL; opnd = 24'h563412;
    run("R7 long", 24'h563412, 2'd0, 0);
    mode = M_AINDL; opnd = 24'h2000;
    run("R7 [a]", {mb(24'h002002), mb(24'h002001), mb(24'h002000)}, 2'd0, 3);
  endtask

  task automatic t_stack();
    logic [24:0] s;
    defaults(); mode = M_SREL; sptr = 16'h01F0; opnd = 24'h20;
    run("R8 stack relative", 24'h000210, 2'd1, 0);
    mode = M_SRINDY; dbank = 8'hFF; yreg = 16'hFFFF;
    s = {1'b0, 8'hFF, mb(24'h000211), mb(24'h000210)} + 25'h0FFFF;
    run("R8 (s,S),Y 24-bit wrap", s[23:0], 2'd2, 2);
  endtask

  task automatic t_rel();
    defaults(); mode = M_REL; pc = 16'h8005; opnd = 24'hFB;
    run("R9 branch back", 24'h7E8000, 2'd0, 0);
    pc = 16'hFFF0; opnd = 24'h20;
    run("R9 branch wrap", 24'h7E0010, 2'd0, 0);
    mode = M_RELL; pc = 16'h0010; opnd = 24'hFFF0;
    run("R9 long branch wrap", 24'h7E0000, 2'd0, 0);
  endtask

  task automatic t_obus();
    int lat;
    defaults(); mode = M_ABS; opnd = 24'hABCD;
    go(lat); chk("R10 read takes operand high", {16'd0, c_ob}, 24'hAB);
    acc = ACC_WR; opnd = 24'h5566;
    go(lat); chk("R10 write leaves obus", {16'd0, c_ob}, 24'hAB);
    mode = M_ABSL; acc = ACC_CALL; opnd = 24'h001122;
    go(lat); chk("R10 long call takes program bank", {16'd0, c_ob}, 24'h7E);
    mode = M_DIRX; acc = ACC_RD; opnd = 24'h99;
    go(lat); chk("R10 direct read operand", {16'd0, c_ob}, 24'h99);
    mode = M_AXIND; acc = ACC_CALL; pc = 16'h4321; opnd = 24'h1000; xreg = 16'h0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 (a,X) call PC low mid-fetch", {16'd0, obus}, 24'h21);
    lat = 0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk("R10 (a,X) call final pointer high", {16'd0, obus}, {16'd0, mb(24'h7E1001)});
  endtask

  task automatic t_handshake();
    int ndone;
    int lat;
    logic [23:0] got;
    defaults(); mode = M_DIND; dpage = 16'h0000; opnd = 24'h50; stall = 1'b1;
    ndone = 0; got = '0; lat = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (done) begin ndone++; got = ea; end
    mode = M_ABS; opnd = 24'h0042; start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 1;
    for (int i = 0; i < 15; i++) begin
      if (done) begin ndone++; got = ea; end
      if (ndone == 0) lat++;
      @(negedge clk);
    end
    chk("R11 one done under stall", 24'(ndone), 24'd1);
    chk("R11 stalled result", got, {8'h12, mb(24'h000051), mb(24'h000050)});
    chk("R11 stall latency at least 2", 24'(lat >= 2), 24'd1);
    stall = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_dindex();
    t_dind_wrap();
    t_penalty();
    t_absxind();
    t_long();
    t_stack();
    t_rel();
    t_obus();
    t_handshake();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule